// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host-side master for a 64-word by 16-bit serial EEPROM. Each word is reached through a frame that is clocked in bit by bit. A requester hands over one command at a time on a valid/ready handshake. A command is an operation code, a 6-bit word address, a 16-bit data word for the write operations, and a word count for reads. The block then produces chip select, serial clock and serial data-in. It shifts out the frame, and on reads it collects the words that come back on serial data-out. Each collected word is presented for one cycle with a valid strobe.

Both write-type operations end with a status wait. The controller drops chip select for a minimum time, then raises it again with the clock held still and data-in held low. It watches data-out until the device reports ready. A parameterised timeout ends the wait early and raises an error flag. Clock half-period, minimum select-low time and poll limit are all counts of system clock cycles. With the defaults at a 50 MHz system clock these are 23, 23 and 500000. That gives at least 450 ns per clock level, at least 450 ns of deselect, and 10 ms of polling.

Top module: `mw_eeprom_host`

## Requirements
- R1: Every frame starts, at the first serial clock rise after select goes high, with a 1 start bit. The two operation bits follow, then six address bits, most significant first. Data-in changes only while the serial clock is low.
- R2: The transmitted header uses these codes. Read (req_op 0) is 10 followed by the address. Write (req_op 1) is 01, the address, then 16 data bits. Enable writes (req_op 2) is 00 then 110000. Disable writes (req_op 3) is 00 then 000000. Fill-all (req_op 4) is 00 then 010000, then 16 data bits. req_op values 5 to 7 send the disable-writes frame.
- R3: On a read, the bit returned alongside the last address bit is discarded. The next 16 bits sampled at serial clock rises form one word on rd_data, and rd_valid is high for one cycle.
- R4: A read returns req_count+1 words from consecutive addresses, wrapping from 63 to 0. Select stays high across the whole transfer.
- R5: Select goes low at the end of every frame and every status wait. The serial clock is low whenever select is low. Select stays low for at least CSL_DIV cycles before it rises again.
- R6: After a write or fill-all frame, select stays low for CSL_DIV cycles. Select then rises with the serial clock low and data-in low, and stays high until data-out reads 1.
- R7: If data-out stays 0 for POLL_LIMIT cycles of the status wait, select drops and err_timeout goes high. err_timeout clears when the next command is accepted.
- R8: req_ready is low from acceptance until select has come back low after the command and its deselect time has passed. A request offered while req_ready is low is ignored.
- R9: Inside a frame, each high level and each low level of the serial clock lasts exactly HALF_DIV system cycles. This includes the low time between select rising and the first clock rise.
- R10: In reset, select, serial clock and data-in are low. req_ready is high, and rd_valid and err_timeout are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Controller idle, command will be taken |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Data for write and fill-all |
| req_count | input | 6 | Read length minus one |
| rd_valid | output | 1 | One-cycle strobe for a returned word |
| rd_data | output | 16 | Returned word |
| err_timeout | output | 1 | Status wait timed out |
| ser_cs | output | 1 | Chip select to the device |
| ser_sk | output | 1 | Serial clock to the device |
| ser_di | output | 1 | Serial data to the device |
| ser_do | input | 1 | Serial data / ready status from the device |

## Verification
The assertions take for granted that the requester holds req_valid and the command fields steady until acceptance, and that data-out is already settled when it is sampled. Under that assumption they check the pin-level rules: clock-still-while-deselected, data stability at clock rises, quiet status polling and the minimum deselect time. The stimulus respects this by changing requests and the device model's data-out only at falling system-clock edges. The device model answers every serial clock rise from its own decode of the incoming bits and holds data-out low for a set busy time after a write. That busy time is raised above the poll limit for the timeout case.

// File: rtl/mw_pkg.sv
package mw_pkg;

  localparam int MW_AW     = 6;
  localparam int MW_DW     = 16;
  localparam int MW_FRAME  = 1 + 2 + MW_AW + MW_DW;
  localparam int MW_RISE_W = 11;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_WREN  = 3'd2,
    OP_WRDIS = 3'd3,
    OP_WRALL = 3'd4
  } mw_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_GAP, S_POLL, S_HOLD
  } mw_state_e;

  // Full left-justified frame: start bit, opcode, address field, data.
  function automatic logic [MW_FRAME-1:0] mw_frame(input logic [2:0] op,
                                                   input logic [MW_AW-1:0] a,
                                                   input logic [MW_DW-1:0] d);
    case (op)
      OP_READ:  return {1'b1, 2'b10, a, {MW_DW{1'b0}}};
      OP_WRITE: return {1'b1, 2'b01, a, d};
      OP_WREN:  return {1'b1, 2'b00, 6'b110000, {MW_DW{1'b0}}};
      OP_WRALL: return {1'b1, 2'b00, 6'b010000, d};
      default:  return {1'b1, 2'b00, 6'b000000, {MW_DW{1'b0}}};
    endcase
  endfunction

  // Number of serial clock rises a command needs while select is high.
  function automatic logic [MW_RISE_W-1:0] mw_rises(input logic [2:0] op,
                                                    input logic [MW_AW-1:0] cnt);
    logic [MW_RISE_W-1:0] words;
    words = MW_RISE_W'(cnt) + MW_RISE_W'(1);
    case (op)
      OP_READ:            return MW_RISE_W'(3 + MW_AW + 1) + (words << 4);
      OP_WRITE, OP_WRALL: return MW_RISE_W'(MW_FRAME);
      default:            return MW_RISE_W'(3 + MW_AW);
    endcase
  endfunction

  function automatic logic mw_needs_poll(input logic [2:0] op);
    return (op == OP_WRITE) || (op == OP_WRALL);
  endfunction

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (!expired) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/mw_rx_word.sv
module mw_rx_word #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          sample,
  input  logic          bit_in,
  output logic          word_valid,
  output logic [DW-1:0] word
);
  localparam int CW = $clog2(DW);

  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] sh;
  logic          last_bit;

  assign last_bit = (bit_cnt == CW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh         <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (restart) begin
        bit_cnt <= '0;
      end else if (sample) begin
        sh      <= {sh[DW-2:0], bit_in};
        bit_cnt <= last_bit ? '0 : bit_cnt + CW'(1);
        if (last_bit) begin
          word       <= {sh[DW-2:0], bit_in};
          word_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_pkg::*;
#(
  parameter int HALF_DIV   = 23,
  parameter int CSL_DIV    = 23,
  parameter int POLL_LIMIT = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [5:0]  req_addr,
  input  logic [15:0] req_wdata,
  input  logic [5:0]  req_count,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        err_timeout,
  output logic        ser_cs,
  output logic        ser_sk,
  output logic        ser_di,
  input  logic        ser_do
);
  localparam int TMAX = (HALF_DIV > CSL_DIV) ? HALF_DIV : CSL_DIV;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_LIMIT + 1);
  localparam logic [MW_RISE_W-1:0] FIRST_DATA_RISE = MW_RISE_W'(3 + MW_AW + 1);

  mw_state_e st_q, st_d;
  logic [2:0]            op_q;
  logic [MW_FRAME-1:0]   frame_q, frame_new;
  logic [MW_RISE_W-1:0]  rises_tot_q, rise_n;
  logic                  cs_q, sk_q, di_q, err_q;
  logic [TW-1:0]         timer_lim;
  logic                  timer_clr, phase_done, to_done;

  // Named internal events
  logic accept, sk_rise_evt, sk_fall_evt, frame_last, poll_active, poll_exit, rd_phase;

  assign frame_new   = mw_frame(req_op, req_addr, req_wdata);
  assign accept      = (st_q == S_IDLE) && req_valid;
  assign sk_rise_evt = (st_q == S_LO) && phase_done;
  assign sk_fall_evt = (st_q == S_HI) && phase_done;
  assign frame_last  = (rise_n == rises_tot_q);
  assign poll_active = (st_q == S_POLL);
  assign poll_exit   = poll_active && (ser_do || to_done);
  assign rd_phase    = (op_q == OP_READ) && (rise_n >= FIRST_DATA_RISE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (req_valid) st_d = S_LO;
      S_LO:   if (phase_done) st_d = S_HI;
      S_HI:   if (phase_done) begin
                if (!frame_last)            st_d = S_LO;
                else if (mw_needs_poll(op_q)) st_d = S_GAP;
                else                        st_d = S_HOLD;
              end
      S_GAP:  if (phase_done) st_d = S_POLL;
      S_POLL: if (ser_do || to_done) st_d = S_HOLD;
      S_HOLD: if (phase_done) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign timer_clr = (st_q != st_d) || (st_q == S_IDLE);
  assign timer_lim = (st_q == S_LO || st_q == S_HI) ? TW'(HALF_DIV) : TW'(CSL_DIV);

  mw_tick #(.W(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(timer_clr), .limit(timer_lim), .expired(phase_done)
  );

  mw_tick #(.W(PW)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(!poll_active), .limit(PW'(POLL_LIMIT)), .expired(to_done)
  );

  mw_rx_word #(.DW(MW_DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .restart(accept), .sample(sk_rise_evt && rd_phase),
    .bit_in(ser_do), .word_valid(rd_valid), .word(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      op_q        <= 3'd0;
      frame_q     <= '0;
      rises_tot_q <= '0;
      rise_n      <= '0;
      cs_q        <= 1'b0;
      sk_q        <= 1'b0;
      di_q        <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q        <= req_op;
        frame_q     <= frame_new;
        rises_tot_q <= mw_rises(req_op, req_count);
        rise_n      <= '0;
        cs_q        <= 1'b1;
        di_q        <= frame_new[MW_FRAME-1];
        err_q       <= 1'b0;
      end
      if (sk_rise_evt) begin
        sk_q   <= 1'b1;
        rise_n <= rise_n + MW_RISE_W'(1);
      end
      if (sk_fall_evt) begin
        sk_q <= 1'b0;
        if (frame_last) begin
          cs_q <= 1'b0;
          di_q <= 1'b0;
        end else begin
          frame_q <= frame_q << 1;
          di_q    <= frame_q[MW_FRAME-2];
        end
      end
      if (st_q == S_GAP && phase_done) begin
        cs_q <= 1'b1;
        di_q <= 1'b0;
      end
      if (poll_exit) begin
        cs_q <= 1'b0;
        if (!ser_do) err_q <= 1'b1;
      end
    end
  end

  assign req_ready   = (st_q == S_IDLE);
  assign ser_cs      = cs_q;
  assign ser_sk      = sk_q;
  assign ser_di      = di_q;
  assign err_timeout = err_q;

endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int CSL_DIV = 23
) (
  input logic clk,
  input logic rst_n,
  input logic ser_cs,
  input logic ser_sk,
  input logic ser_di,
  input logic req_ready,
  input logic rd_valid,
  input logic err_timeout,
  input logic poll_active
);
  int lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lo_cnt <= CSL_DIV;
    else if (ser_cs)           lo_cnt <= 0;
    else if (lo_cnt < CSL_DIV) lo_cnt <= lo_cnt + 1;
  end

  p_di_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sk |-> $stable(ser_di));

  p_sk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs |-> !ser_sk);

  p_cs_low_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs) |-> (lo_cnt >= CSL_DIV));

  p_poll_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active |-> (ser_cs && !ser_sk && !ser_di));

  p_word_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ser_cs);

  p_timeout_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> !ser_cs);

  p_ready_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ser_cs);

endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.CSL_DIV(CSL_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_sk(ser_sk), .ser_di(ser_di),
  .req_ready(req_ready), .rd_valid(rd_valid), .err_timeout(err_timeout),
  .poll_active(poll_active)
);

// File: tb/sim_mw_eeprom_host.sv
module sim_mw_eeprom_host;
  localparam int HALF = 3;
  localparam int CSL  = 4;
  localparam int PLIM = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [5:0]  req_addr = 6'd0;
  logic [15:0] req_wdata = 16'd0;
  logic [5:0]  req_count = 6'd0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        err_timeout;
  logic        ser_cs, ser_sk, ser_di;
  logic        dev_do;

  mw_eeprom_host #(.HALF_DIV(HALF), .CSL_DIV(CSL), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_timeout(err_timeout),
    .ser_cs(ser_cs), .ser_sk(ser_sk), .ser_di(ser_di), .ser_do(dev_do)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- device model and pin monitors ----------------
  logic [15:0] dmem [64];
  logic [15:0] smem [64];
  bit          swen;
  bit          dwen;
  int          dbusy, busy_len;
  int          mst, mcnt, mbit;
  logic [7:0]  mhdr, last_hdr;
  logic [5:0]  maddr, mwaddr;
  logic [15:0] mwd;
  bit          mwall;
  int          frames, cs_rises, busy_viol, sk_run, sk_bad, cs_lo_run, cs_lo_bad, rdy_bad;
  logic        p_sk, p_cs;
  logic [15:0] rq [$];

  always @(negedge clk) begin
    if (!rst_n) begin
      dev_do = 1'b0; dwen = 1'b0; dbusy = 0; mst = 0; mcnt = 0; mbit = 0;
      mhdr = '0; last_hdr = '0; maddr = '0; mwaddr = '0; mwd = '0; mwall = 1'b0;
      frames = 0; cs_rises = 0; busy_viol = 0; sk_run = 0; sk_bad = 0;
      cs_lo_run = CSL; cs_lo_bad = 0; rdy_bad = 0; p_sk = 1'b0; p_cs = 1'b0;
    end else begin
      bit rise;
      if (dbusy > 0) dbusy--;
      rise = ser_sk && !p_sk && ser_cs;
      if (ser_cs && !p_cs) begin
        cs_rises++;
        mst = 0;
        if (cs_lo_run < CSL) cs_lo_bad++;
      end
      if (!ser_cs && p_cs) begin
        if (mst == 3 && mcnt == 16 && dwen) begin
          if (mwall) for (int i = 0; i < 64; i++) dmem[i] = mwd;
          else dmem[mwaddr] = mwd;
          dbusy = busy_len;
        end
        mst = 0;
      end
      if (rise) begin
        case (mst)
          0: if (ser_di) begin mst = 1; mcnt = 0; if (dbusy > 0) busy_viol++; end
          1: begin
               mhdr = {mhdr[6:0], ser_di};
               mcnt++;
               if (mcnt == 8) begin
                 last_hdr = mhdr;
                 frames++;
                 case (mhdr[7:6])
                   2'b10: begin mst = 2; maddr = mhdr[5:0]; mbit = 0; dev_do = 1'b0; end
                   2'b01: begin mst = 3; mcnt = 0; mwall = 1'b0; mwaddr = mhdr[5:0]; end
                   2'b00: case (mhdr[5:4])
                            2'b11: begin dwen = 1'b1; mst = 4; end
                            2'b00: begin dwen = 1'b0; mst = 4; end
                            2'b01: begin mst = 3; mcnt = 0; mwall = 1'b1; end
                            default: mst = 4;
                          endcase
                   default: mst = 4;
                 endcase
               end
             end
          2: begin
               dev_do = dmem[maddr][15 - mbit];
               mbit++;
               if (mbit == 16) begin mbit = 0; maddr++; end
             end
          3: begin if (mcnt < 16) mwd = {mwd[14:0], ser_di}; mcnt++; end
          default: ;
        endcase
      end
      if (ser_cs && mst == 0 && !rise) dev_do = (dbusy == 0);
      // clock level widths inside a frame
      if (ser_sk != p_sk) begin
        if (p_cs && sk_run != HALF) sk_bad++;
        sk_run = 1;
      end else if (ser_cs != p_cs) sk_run = 1;
      else sk_run++;
      if (!ser_cs) cs_lo_run++; else cs_lo_run = 0;
      if (req_ready && ser_cs) rdy_bad++;
      if (rd_valid) rq.push_back(rd_data);
      p_sk = ser_sk;
      p_cs = ser_cs;
    end
  end

  // ---------------- expectations ----------------
  int exp_rises = 0;

  function automatic logic [7:0] exp_hdr(input logic [2:0] op, input logic [5:0] a);
    case (op)
      3'd0: return {2'b10, a};
      3'd1: return {2'b01, a};
      3'd2: return 8'b0011_0000;
      3'd4: return 8'b0001_0000;
      default: return 8'h00;
    endcase
  endfunction

  task automatic send(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                      input logic [5:0] c);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_count = c; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                        input logic [5:0] c);
    send(op, a, d, c);
    case (op)
      3'd1: if (swen) smem[a] = d;
      3'd2: swen = 1'b1;
      3'd4: if (swen) for (int i = 0; i < 64; i++) smem[i] = d;
      3'd0: ;
      default: swen = 1'b0;
    endcase
    exp_rises += (op == 3'd1 || op == 3'd4) ? 2 : 1;
    chk(last_hdr == exp_hdr(op, a), "R2 header", {24'h0, last_hdr}, {24'h0, exp_hdr(op, a)});
  endtask

  task automatic do_read(input logic [5:0] a, input logic [5:0] c);
    rq.delete();
    do_cmd(3'd0, a, 16'h0, c);
    chk(rq.size() == int'(c) + 1, "R4 word count", rq.size(), int'(c) + 1);
    for (int k = 0; k < rq.size() && k <= int'(c); k++)
      chk(rq[k] == smem[6'(a + 6'(k))], "R3 read word", rq[k], smem[6'(a + 6'(k))]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 64; i++) begin dmem[i] = 16'($urandom); smem[i] = dmem[i]; end
    swen = 1'b0;
    busy_len = 40;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({ser_cs, ser_sk, ser_di} == 3'b000, "R10 pins", {29'h0, ser_cs, ser_sk, ser_di}, 0);
    chk(req_ready && !rd_valid && !err_timeout, "R10 handshake",
        {29'h0, req_ready, rd_valid, err_timeout}, 32'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2: enable writes, then a directed write and read-back
    do_cmd(3'd2, 6'd0, 16'h0, 6'd0);
    chk(dwen == 1'b1, "R2 enable decoded", dwen, 1);
    do_cmd(3'd1, 6'd5, 16'hA5C3, 6'd0);
    chk(dbusy == 0, "R6 waited for ready", dbusy, 0);
    chk(dmem[5] == 16'hA5C3, "R1 written word", dmem[5], 16'hA5C3);
    do_read(6'd5, 6'd0);

    // R4 multi-word read across the top address
    do_cmd(3'd1, 6'd63, 16'h1357, 6'd0);
    do_read(6'd62, 6'd3);

    // R8 request held during a write is not taken
    begin
      int f0;
      f0 = frames;
      while (!req_ready) @(negedge clk);
      req_op = 3'd1; req_addr = 6'd9; req_wdata = 16'h0F0F; req_valid = 1'b1;
      @(negedge clk);
      req_op = 3'd3;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b0;
      smem[9] = 16'h0F0F;
      exp_rises += 2;
      repeat (CSL + 4) @(negedge clk);
      chk(frames == f0 + 1, "R8 extra request ignored", frames, f0 + 1);
      chk(dwen == 1'b1, "R8 disable not sent", dwen, 1);
    end

    // R2 disable then write has no effect
    do_cmd(3'd3, 6'd0, 16'h0, 6'd0);
    do_cmd(3'd1, 6'd9, 16'hDEAD, 6'd0);
    chk(dmem[9] == 16'h0F0F, "R2 write while disabled", dmem[9], 16'h0F0F);
    do_cmd(3'd7, 6'd0, 16'h0, 6'd0);

    // R2 fill-all, then read everything back
    do_cmd(3'd2, 6'd0, 16'h0, 6'd0);
    do_cmd(3'd4, 6'd0, 16'h6C6C, 6'd0);
    do_read(6'd0, 6'd63);

    // R7 status wait runs out
    busy_len = 1000;
    do_cmd(3'd1, 6'd17, 16'hBEEF, 6'd0);
    chk(err_timeout == 1'b1, "R7 timeout flag", err_timeout, 1);
    chk(dbusy > 0, "R7 gave up while busy", dbusy, 1);
    repeat (1000) @(negedge clk);
    busy_len = 40;
    do_cmd(3'd2, 6'd0, 16'h0, 6'd0);
    chk(err_timeout == 1'b0, "R7 flag cleared", err_timeout, 0);

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      int r;
      logic [5:0] a;
      r = int'($urandom % 6);
      a = 6'($urandom);
      case (r)
        0, 5: do_read(a, 6'($urandom % 4));
        1, 4: do_cmd(3'd1, a, 16'($urandom), 6'd0);
        2:    do_cmd(3'd2, a, 16'h0, 6'd0);
        default: do_cmd(3'd3, a, 16'h0, 6'd0);
      endcase
    end
    do_read(6'd0, 6'd7);

    repeat (CSL + 4) @(negedge clk);
    chk(sk_bad == 0, "R9 clock level width", sk_bad, 0);
    chk(cs_lo_bad == 0, "R5 deselect time", cs_lo_bad, 0);
    chk(cs_rises == exp_rises, "R5 R6 select rises", cs_rises, exp_rises);
    chk(rdy_bad == 0, "R8 ready while selected", rdy_bad, 0);
    chk(busy_viol == 0, "R6 frame sent while busy", busy_viol, 0);
    finish_run();
  end
endmodule